// File: doc/BRIEF.md
# Nearest Power-of-Two Radix Selector

This block takes an unsigned operand and returns the power of two that lies closest to it, along with the exponent of that power. Suppose the operand's most significant set bit sits at position p. The operand then falls between 2^p and 2^(p+1). The block compares it with the midpoint of that span, 3·2^(p-1). If the operand lies strictly above the midpoint, the upper power is returned. Otherwise the lower power is returned. The result is meant as the base for a multiplier that works with residuals against a nearby power of two, so the residual stays as small as possible.

A request is a single-cycle `start` pulse with the operand on `x`. The block finds p with a serial search. A register holding the operand shifts left one place per cycle while a counter counts down from W-1, and the search stops when the top bit is set. One more cycle forms both candidate radices and their midpoint, compares the operand with the midpoint, and registers the chosen radix with a one-cycle `done` pulse. The radix output is one bit wider than the operand, because rounding up from the top span gives 2^W.

Top module: `radix_pick`

## Requirements
- R1: While reset is asserted and right after it, `done` is 0, `radix` is 0 and `radix_exp` is 0.
- R2: For an operand whose leading one is at bit p, `done` goes high exactly W-p+1 clock cycles after the edge that samples `start`. It stays high for exactly one cycle.
- R3: If the operand is strictly greater than 3·2^(p-1), `radix` is 2^(p+1) and `radix_exp` is p+1.
- R4: If the operand is less than or equal to 3·2^(p-1), `radix` is 2^p and `radix_exp` is p. An operand exactly at the midpoint (for example 3, 6 or 0xC000 at W=16) rounds down.
- R5: The operand 1 (p=0, midpoint taken as 1.5) gives `radix` 1 and `radix_exp` 0 after 17 cycles when W=16.
- R6: An operand above 3·2^(W-2) gives `radix` 2^W, which is carried in bit W of `radix`, and `radix_exp` W.
- R7: The operand 0 is treated as p=0. It gives `radix` 1 and `radix_exp` 0 after W+1 cycles.
- R8: A `start` pulse while a request is in progress is ignored. The result reported belongs to the operand that began the search.
- R9: Between `done` pulses, `radix` and `radix_exp` hold their last values regardless of `x`.
- R10: Whenever `done` is high, `radix` has exactly one bit set, at position `radix_exp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a request with the operand on `x` |
| x | input | W | Unsigned operand, sampled with `start` |
| done | output | 1 | One-cycle pulse: result valid |
| radix | output | W+1 | Chosen power of two |
| radix_exp | output | $clog2(W+1) | Exponent of `radix` |

## Verification
The hardest cases to reach are the ones next to the comparison boundary. One is an operand exactly on the midpoint, which must round down. The other is an operand just above the midpoint in the top span, which must raise the extra output bit. The bench drives these directly (3, 6, 0xC000, 0xC001, 0xFFFF), together with the zero operand that runs the search to its end. It also overlaps a second `start` with a request in progress, using an operand that would give a different answer, so the ignored pulse can be seen at the output.

// File: rtl/radix_pick.sv
module radix_pick #(
  parameter int W = 16,
  localparam int EW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  x,
  output logic          done,
  output logic [W:0]    radix,
  output logic [EW-1:0] radix_exp
);

  typedef enum logic [1:0] {IDLE, SEARCH, PICK} st_t;

  st_t           st;
  logic [W-1:0]  xr, sh;
  logic [EW-1:0] cnt, p;

  wire [EW-1:0] p1  = p + 1'b1;
  wire [W:0]    one = {{W{1'b0}}, 1'b1};
  wire [W:0]    lo  = one << p;
  wire [W:0]    hi  = one << p1;
  wire [W+1:0]  sum = {1'b0, lo} + {1'b0, hi};
  wire [W:0]    mid = sum[W+1:1];
  wire          up  = {1'b0, xr} > mid;
  wire          hit = sh[W-1] || (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      xr        <= '0;
      sh        <= '0;
      cnt       <= '0;
      p         <= '0;
      done      <= 1'b0;
      radix     <= '0;
      radix_exp <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          xr  <= x;
          sh  <= x;
          cnt <= EW'(W - 1);
          st  <= SEARCH;
        end
        SEARCH: if (hit) begin
          p  <= cnt;
          st <= PICK;
        end else begin
          sh  <= sh << 1;
          cnt <= cnt - 1'b1;
        end
        PICK: begin
          radix     <= up ? hi : lo;
          radix_exp <= up ? p1 : p;
          done      <= 1'b1;
          st        <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

endmodule

// File: rtl/radix_pick_chk.sv
module radix_pick_chk #(
  parameter int W = 16,
  localparam int EW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [W:0]    radix,
  input logic [EW-1:0] radix_exp,
  input logic [W-1:0]  xr
);

  wire [W+2:0] x4 = {xr, 2'b00};
  wire [W+2:0] r3 = {2'b00, radix} + {1'b0, radix, 1'b0};
  wire [W+2:0] x1 = {3'b000, xr};
  wire [W+2:0] r2 = {1'b0, radix, 1'b0};

  assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot(radix));

  assert_exp_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> radix[radix_exp]);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(radix) && $stable(radix_exp)));

  // R3 and R4: the chosen radix lies in [x/2, 4x/3]
  assert_near_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && xr != '0) |-> ((x4 >= r3) && (x1 < r2)));

endmodule

bind radix_pick radix_pick_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done),
  .radix(radix), .radix_exp(radix_exp), .xr(xr)
);

// File: tb/radix_pick_test.sv
`timescale 1ns/1ps
module radix_pick_test;
  localparam int W  = 16;
  localparam int EW = $clog2(W + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0]  x = '0;
  logic          done;
  logic [W:0]    radix;
  logic [EW-1:0] radix_exp;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  radix_pick #(.W(W)) uut (.clk(clk), .rst_n(rst_n), .start(start), .x(x),
    .done(done), .radix(radix), .radix_exp(radix_exp));

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lead(longint v);
    int p = 0;
    for (int i = 0; i < W; i++) if (v[i]) p = i;
    return p;
  endfunction

  task automatic run(string req, longint v);
    int p = lead(v);
    int cyc = 0;
    longint er, ee;
    bit upp = (2 * v) > (3 * (64'd1 << p));
    er = upp ? (64'd1 << (p + 1)) : (64'd1 << p);
    ee = upp ? p + 1 : p;
    @(negedge clk); start = 1; x = v[W-1:0];
    @(negedge clk); start = 0;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    check({req, " latency"}, cyc, W - p + 1);
    check({req, " radix"}, radix, er);
    check({req, " exp"}, radix_exp, ee);
    @(negedge clk);
    check("R2 pulse", done, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 done", done, 0);
    check("R1 radix", radix, 0);
    check("R1 exp", radix_exp, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after", {done, radix, radix_exp}, 0);
  endtask

  task automatic t_busy();
    int cyc = 0;
    @(negedge clk); start = 1; x = 16'd7;
    @(negedge clk); start = 1; x = 16'hFFFF;
    @(negedge clk); start = 0;
    cyc = 1;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    check("R8 latency", cyc, W - 2 + 1);
    check("R8 radix", radix, 8);
    check("R8 exp", radix_exp, 3);
  endtask

  task automatic t_hold();
    logic [W:0] r0 = radix;
    logic [EW-1:0] e0 = radix_exp;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); x = W'(i * 977);
    end
    check("R9 radix", radix, r0);
    check("R9 exp", radix_exp, e0);
    check("R9 done", done, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    run("R5", 1);
    run("R7", 0);
    run("R4", 2);
    run("R4", 3);
    run("R4", 6);
    run("R3", 7);
    run("R3", 100);
    run("R3", 1000);
    run("R4", 16'hC000);
    run("R6", 16'hC001);
    run("R6", 16'hFFFF);
    t_busy();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule